// File: doc/BRIEF.md
# Word Buffer with Threshold Requests and Sticky Events

This block is the word-wide staging buffer between a bus master and a serial flash sequencer. It holds up to 2^DEPTH_LOG2 words of DW bits each. By default that is 64 words of 32 bits. A direction bit picks the roles of the two sides. In receive direction the sequencer pushes words and the bus pops them by reading the data register. In transmit direction the bus pushes words by writing the data register and the sequencer pops them.

A programmable threshold turns the fill level into a receive or transmit service request. Five events are kept as sticky flags: end of transfer, transmit request, receive request, overflow and underflow. Each flag is cleared by writing a one to it and can be masked individually. The unmasked flags are combined into a single interrupt line. A flush command empties the buffer.

Top module: `wordbuf_evt`

## Requirements
- R1: After reset the count is 0, every flag is 0, the mask is 5'h1F, the threshold is all ones (2^DEPTH_LOG2-1), the direction is receive, and irq is 0.
- R2: Words leave in the order they were accepted. The status count field, at bits [16 +: DEPTH_LOG2+1], gives the number of words held.
- R3: A push while the buffer is full drops the word, leaves the count unchanged, and sets the overflow flag (bit 1).
- R4: A pop while the buffer is empty returns 0, leaves the count at 0, and sets the underflow flag (bit 0).
- R5: Each direction ignores the strobes of the wrong side. With CTRL bit 8 = 0 (receive), seq_push pushes and a bus read of DATA pops, while bus writes to DATA and seq_pop are ignored. With bit 8 = 1 (transmit), a bus write to DATA pushes and seq_pop pops, while seq_push and bus reads of DATA do not change the buffer.
- R6: In receive direction the receive-request flag (bit 2) is set whenever the count after an edge is greater than the threshold.
- R7: In transmit direction the transmit-request flag (bit 3) is set whenever the free space (2^DEPTH_LOG2 minus count) after an edge is greater than the threshold.
- R8: A seq_done pulse sets the end flag (bit 4).
- R9: A flag stays set until a CLEAR write has a one in its bit. Zero bits in that write leave their flags unchanged. An event in the same cycle as its clear keeps the flag set.
- R10: irq is the OR over the five flags of (flag AND NOT mask bit). A mask bit of 1 blocks that flag.
- R11: A CTRL write with bit 16 set empties the buffer (count 0). Any push or pop in the same cycle is discarded without raising overflow or underflow, and the other flags are left as they were.
- R12: The register map is as follows. Address 0 is CTRL: threshold in [DEPTH_LOG2-1:0], direction in [8], flush in [16], and the flush bit reads 0. Address 1 is STATUS, read-only: flags in [4:0], count in [16 +: DEPTH_LOG2+1], and writes have no effect. Address 2 is CLEAR, which reads 0. Address 3 is MASK, in [4:0]. Address 4 is DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on DATA) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| seq_push | input | 1 | Sequencer push strobe |
| seq_wdata | input | DW | Sequencer push word |
| seq_pop | input | 1 | Sequencer pop strobe |
| seq_rdata | output | DW | Head word, 0 when empty |
| seq_done | input | 1 | End-of-transfer pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH_LOG2 = 3, which gives an eight-word buffer and a three-bit threshold. At that size every threshold value can be swept against every fill level in both directions, from empty through full and one push past full. Every mask value is also applied to a known flag pattern. The request, overflow and underflow boundaries are all reached within a few thousand cycles.

// File: rtl/wordbuf_evt.sv
module wordbuf_evt #(
  parameter int DW         = 32,
  parameter int DEPTH_LOG2 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          seq_push,
  input  logic [DW-1:0] seq_wdata,
  input  logic          seq_pop,
  output logic [DW-1:0] seq_rdata,
  input  logic          seq_done,
  output logic          irq
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int TW    = DEPTH_LOG2;
  localparam int CW    = DEPTH_LOG2 + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CLR = 3'd2, A_MASK = 3'd3, A_DATA = 3'd4;
  localparam int F_UND = 0, F_OVF = 1, F_RRQ = 2, F_TRQ = 3, F_END = 4;
  localparam int CNT_LSB = 16, DIR_BIT = 8, FLUSH_BIT = 16;

  logic [DW-1:0] mem [DEPTH];
  logic [TW-1:0] wp_q, rp_q, thr_q, thr_nx;
  logic [CW-1:0] cnt_q, cnt_nx, free_nx;
  logic          dir_q, dir_nx;
  logic [4:0]    flags_q, mask_q, clr_vec, evt;
  logic          wr_ctrl, flush, push_req, pop_req, push_ok, pop_ok, full, empty;
  logic [DW-1:0] push_word, head;

  assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  assign flush     = wr_ctrl && reg_wdata[FLUSH_BIT];
  assign push_req  = dir_q ? (reg_wr && reg_addr == A_DATA) : seq_push;
  assign push_word = dir_q ? reg_wdata : seq_wdata;
  assign pop_req   = dir_q ? seq_pop : (reg_rd && reg_addr == A_DATA);
  assign full      = cnt_q == DEPTH_C;
  assign empty     = cnt_q == '0;
  assign push_ok   = push_req && !full && !flush;
  assign pop_ok    = pop_req && !empty && !flush;
  assign head      = empty ? '0 : mem[rp_q];
  assign seq_rdata = head;

  assign thr_nx = wr_ctrl ? reg_wdata[TW-1:0] : thr_q;
  assign dir_nx = wr_ctrl ? reg_wdata[DIR_BIT] : dir_q;

  always_comb begin
    if (flush) cnt_nx = '0;
    else begin
      case ({push_ok, pop_ok})
        2'b10:   cnt_nx = cnt_q + CNT_ONE;
        2'b01:   cnt_nx = cnt_q - CNT_ONE;
        default: cnt_nx = cnt_q;
      endcase
    end
  end
  assign free_nx = DEPTH_C - cnt_nx;

  always_comb begin
    evt        = '0;
    evt[F_UND] = pop_req && empty && !flush;
    evt[F_OVF] = push_req && full && !flush;
    evt[F_RRQ] = !dir_nx && (cnt_nx > {1'b0, thr_nx});
    evt[F_TRQ] = dir_nx && (free_nx > {1'b0, thr_nx});
    evt[F_END] = seq_done;
  end

  assign clr_vec = (reg_wr && reg_addr == A_CLR) ? reg_wdata[4:0] : 5'b0;
  assign irq     = |(flags_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      thr_q   <= '1;
      dir_q   <= 1'b0;
      flags_q <= '0;
      mask_q  <= 5'h1F;
    end else begin
      cnt_q   <= cnt_nx;
      thr_q   <= thr_nx;
      dir_q   <= dir_nx;
      flags_q <= (flags_q & ~clr_vec) | evt;
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[4:0];
      if (flush) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (push_ok) wp_q <= wp_q + 1'b1;
        if (pop_ok)  rp_q <= rp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_word;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[TW-1:0]  = thr_q;
        reg_rdata[DIR_BIT] = dir_q;
      end
      A_STAT: begin
        reg_rdata[4:0]          = flags_q;
        reg_rdata[CNT_LSB +: CW] = cnt_q;
      end
      A_MASK:  reg_rdata[4:0] = mask_q;
      A_DATA:  reg_rdata = head;
      default: reg_rdata = '0;
    endcase
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_ONE || cnt_q == $past(cnt_q) - CNT_ONE));
  a_r3_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_ok && !flush) |=> (cnt_q == DEPTH_C && flags_q[F_OVF]));
  a_r4_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_ok && !flush) |=> (cnt_q == '0 && flags_q[F_UND]));
  a_r8_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> flags_q[F_END]);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ($past(flags_q) & ~$past(clr_vec))) == ($past(flags_q) & ~$past(clr_vec))));
  a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);
endmodule

// File: tb/wordbuf_evt_tb_top.sv
module wordbuf_evt_tb_top;
  localparam int DW = 32, LG = 3, DEP = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, seq_push = 0, seq_pop = 0, seq_done = 0;
  logic [2:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, seq_wdata = 0, reg_rdata, seq_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] st, d;

  always #5 clk = ~clk;

  wordbuf_evt #(.DW(DW), .DEPTH_LOG2(LG)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_push(seq_push), .seq_wdata(seq_wdata),
    .seq_pop(seq_pop), .seq_rdata(seq_rdata), .seq_done(seq_done), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask
  task automatic bus_pop(output logic [31:0] v);
    @(negedge clk); reg_addr = 3'd4; reg_rd = 1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic spush(input logic [31:0] v);
    @(negedge clk); seq_push = 1; seq_wdata = v;
    @(negedge clk); seq_push = 0;
  endtask
  task automatic spop(output logic [31:0] v);
    @(negedge clk); seq_pop = 1; #1 v = seq_rdata;
    @(negedge clk); seq_pop = 0;
  endtask
  task automatic sdone();
    @(negedge clk); seq_done = 1;
    @(negedge clk); seq_done = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, st); chk("R1 ctrl", st, 32'h7);
    rd(1, st); chk("R1 status", st, 32'h0);
    rd(3, st); chk("R1 mask", st, 32'h1F);
    rd(2, st); chk("R12 clear reads 0", st, 32'h0);
    chk("R1 irq", irq, 0);

    // receive sweep: R2 R3 R4 R6 R9
    for (int t = 0; t < DEP; t++) begin
      wr(0, 32'h1_0000 | t);
      wr(2, 32'h1F);
      for (int n = 1; n <= DEP; n++) begin
        spush((t << 8) | n);
        rd(1, st);
        chk("R2 count", st[19:16], n);
        chk("R6 rreq", st[2], n > t);
      end
      spush(32'hDEAD);
      rd(1, st);
      chk("R3 over flag", st[1], 1);
      chk("R3 count held", st[19:16], DEP);
      for (int n = 1; n <= DEP; n++) begin
        bus_pop(d);
        chk("R2 order rx", d, (t << 8) | n);
      end
      rd(1, st);
      chk("R9 rreq sticky", st[2], 1);
      chk("R2 count empty", st[19:16], 0);
      bus_pop(d);
      chk("R4 zero data", d, 0);
      rd(1, st);
      chk("R4 under flag", st[0], 1);
      chk("R4 count zero", st[19:16], 0);
      wr(2, 32'h04);
      rd(1, st);
      chk("R9 w1c one bit", st[4:0], 5'b00011);
    end

    // transmit sweep: R7 R2 R3 R4 R9
    for (int t = 0; t < DEP; t++) begin
      wr(0, 32'h1_0100 | t);
      wr(2, 32'h1F);
      rd(1, st);
      chk("R7 treq empty", st[3], 1);
      for (int n = 1; n <= DEP; n++) begin
        wr(4, (t << 12) | n);
        wr(2, 32'h08);
        rd(1, st);
        chk("R7 treq", st[3], (DEP - n) > t);
        chk("R2 count tx", st[19:16], n);
      end
      wr(4, 32'hBEEF);
      rd(1, st);
      chk("R3 over tx", st[1], 1);
      chk("R3 count tx", st[19:16], DEP);
      for (int n = 1; n <= DEP; n++) begin
        spop(d);
        chk("R2 order tx", d, (t << 12) | n);
      end
      spop(d);
      chk("R4 zero tx", d, 0);
      rd(1, st);
      chk("R4 under tx", st[0], 1);
    end

    // R5 wrong-side strobes
    wr(0, 32'h1_0107);
    wr(4, 32'hA1);
    spush(32'hB2);
    rd(1, st); chk("R5 tx ignores seq_push", st[19:16], 1);
    bus_pop(d);
    rd(1, st); chk("R5 tx ignores bus pop", st[19:16], 1);
    spop(d); chk("R5 tx data", d, 32'hA1);
    wr(0, 32'h1_0007);
    spush(32'hC1);
    wr(4, 32'hD2);
    rd(1, st); chk("R5 rx ignores bus write", st[19:16], 1);
    spop(d);
    rd(1, st); chk("R5 rx ignores seq_pop", st[19:16], 1);
    bus_pop(d); chk("R5 rx data", d, 32'hC1);

    // R8 end flag, R9 zero write, R12 status write ignored
    wr(2, 32'h1F);
    sdone();
    rd(1, st); chk("R8 end flag", st[4:0], 5'b10000);
    wr(2, 32'h0);
    rd(1, st); chk("R9 zero clear", st[4:0], 5'b10000);
    wr(1, 32'hFFFF_FFFF);
    rd(1, st); chk("R12 status write ignored", st, 32'h10);

    // R11 flush with a simultaneous push
    spush(1); spush(2); spush(3);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'h1_0007; seq_push = 1; seq_wdata = 9;
    @(negedge clk); reg_wr = 0; seq_push = 0;
    rd(1, st);
    chk("R11 flush count", st[19:16], 0);
    chk("R11 flags kept", st[4:0], 5'b10000);
    bus_pop(d); chk("R11 empty after flush", d, 0);

    // R10 mask sweep on flags 10111
    wr(0, 32'h1_0007);
    wr(2, 32'h1F);
    for (int n = 0; n <= DEP; n++) spush(n);
    for (int n = 0; n <= DEP; n++) bus_pop(d);
    sdone();
    rd(1, st); chk("R10 flag pattern", st[4:0], 5'b10111);
    for (int m = 0; m < 32; m++) begin
      wr(3, m);
      chk("R10 irq", irq, |(5'b10111 & ~m[4:0]));
      rd(3, st); chk("R12 mask readback", st, m);
    end
    wr(2, 32'h1F);
    chk("R10 irq after clear", irq, 0);

    finish_run();
  end
endmodule